// File: doc/BRIEF.md
# Byte-Wide Command-Framed Cartridge Read Responder

This block is the card side of a synchronous, byte-wide cartridge bus. The host owns the clock and an active-low select. Every rising edge moves one byte. Once select goes low, the responder takes in a fixed eight-byte command. It reads an opcode and a start address from that command. It then streams bytes from an internal read-only array until the host raises select again.

One opcode starts data on the edge straight after the command. A second opcode first holds the bus released for a programmable number of idle clocks. Data runs through the array in 512-byte blocks. The host may stop partway through a block, or keep clocking into further blocks. A flag pulses on each block boundary crossed. The array address wraps at the array size.

Data moves on separate in, out and enable ports. The pad ring merges them into one tri-state bus.

Top module: `cart_responder`

## Requirements
- R1: After reset, and while select is high, `dq_oe` is 0, `dq_out` is 0x00 and `blk_mark` is 0.
- R2: With select low, the first eight rising edges each sample one command byte from `dq_in`. `dq_oe` stays 0 for the whole command.
- R3: Command bytes 1 to 4 form a big-endian start address, most significant byte first, taken modulo `MEM_BYTES`. The values of bytes 5, 6 and 7 have no effect on the data returned.
- R4: Opcode 0xB7 (byte 0) is an immediate read. The first data byte is on `dq_out`, with `dq_oe` high, for the 9th rising edge of the transfer.
- R5: Opcode 0x3C is a delayed read. `dq_oe` stays 0 for `WAIT_CYCLES` edges after the command. The first data byte is presented for edge 9+`WAIT_CYCLES`.
- R6: Each further edge returns the byte at the next address. The address wraps from `MEM_BYTES`-1 to 0.
- R7: The byte stored at address a is (37·a + 11·floor(a/256) + 29) mod 256.
- R8: `blk_mark` is high exactly while the byte presented sits at an address that is a multiple of `BLOCK_BYTES` (512), except for the first byte of a transfer.
- R9: Any other opcode makes the responder drive 0xFF on every edge, starting at the 9th.
- R10: Raising select releases `dq_oe` at once, with no clock needed, and ends the transfer. The next low period starts a fresh command.
- R11: Values on `dq_in` during the data phase have no effect on the returned stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-driven bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset to idle |
| cs_n | input | 1 | Active-low card select; a low period frames one transfer |
| dq_in | input | 8 | Byte received from the bus pins |
| dq_out | output | 8 | Byte to drive onto the bus pins |
| dq_oe | output | 1 | Pin drive enable; 0 means the pins are released |
| blk_mark | output | 1 | High while the presented byte opens a new 512-byte block |

## Verification
Inputs and outputs are both handled on the falling edge. A value read at a falling edge is the one the host would capture on the following rising edge.

- Command: the bench reads `dq_oe` low at each of the eight falling edges of the command.
- Immediate read and unknown opcodes: the first byte is expected at the falling edge just after the eighth command byte.
- Delayed read: the bench first sees exactly `WAIT_CYCLES` falling edges with the bus released.
- Data stream: each later falling edge must show the next address's byte and its block flag.
- Deselect: `dq_oe` is checked one nanosecond after select rises, with no clock edge in between.

// File: rtl/cart_pkg.sv
`timescale 1ns/1ps
package cart_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_DATA = 2'd2,
        SQ_FILL = 2'd3
    } seq_state_e;

    localparam int          CMD_BYTES    = 8;
    localparam logic [7:0]  OP_READ_NOW  = 8'hB7;
    localparam logic [7:0]  OP_READ_LATE = 8'h3C;
    localparam logic [7:0]  FILL_VALUE   = 8'hFF;

    // Stored content of the read-only array, computed rather than tabulated.
    function automatic logic [7:0] cell_value(input int unsigned a);
        logic [31:0] s;
        s = a * 32'd37 + (a >> 8) * 32'd11 + 32'd29;
        return s[7:0];
    endfunction

endpackage

// File: rtl/cart_cmd_capture.sv
`timescale 1ns/1ps
module cart_cmd_capture #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic [7:0]    din,
    output logic          last_byte,
    output logic [7:0]    opcode,
    output logic [AW-1:0] start_addr
);
    import cart_pkg::*;

    localparam int IW = 4;

    typedef struct packed {
        logic [IW-1:0] idx;
        logic [7:0]    op;
        logic [AW-1:0] addr;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [AW+7:0] shifted;

    assign shifted = {cap_q.addr, din};

    always_comb begin
        cap_d = cap_q;
        if (cs_n) begin
            cap_d.idx = '0;
        end else if (cap_q.idx < IW'(CMD_BYTES)) begin
            if (cap_q.idx == '0) begin
                cap_d.op = din;
            end else if (cap_q.idx <= IW'(4)) begin
                cap_d.addr = shifted[AW-1:0];
            end
            cap_d.idx = cap_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign last_byte  = !cs_n && (cap_q.idx == IW'(CMD_BYTES - 1));
    assign opcode     = cap_q.op;
    assign start_addr = cap_q.addr;

endmodule

// File: rtl/cart_rom.sv
`timescale 1ns/1ps
module cart_rom #(
    parameter int MEM_BYTES = 1024,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    import cart_pkg::*;

    logic [7:0] cells [MEM_BYTES];

    for (genvar i = 0; i < MEM_BYTES; i++) begin : g_cell
        assign cells[i] = cell_value(i);
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/cart_seq.sv
`timescale 1ns/1ps
module cart_seq #(
    parameter int AW          = 10,
    parameter int BLOCK_BYTES = 512,
    parameter int WAIT_CYCLES = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          last_byte,
    input  logic [7:0]    opcode,
    input  logic [AW-1:0] cmd_addr,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          drive,
    output logic [7:0]    dout,
    output logic          mark
);
    import cart_pkg::*;

    localparam int CW = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;
    localparam int BW = $clog2(BLOCK_BYTES);
    localparam int MW = (BW < AW) ? BW : AW;

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic          drive;
        logic [7:0]    dout;
        logic          mark;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        case (seq_q.st)
            SQ_WAIT: rd_addr = seq_q.addr;
            SQ_DATA: rd_addr = seq_q.addr + 1'b1;
            default: rd_addr = cmd_addr;
        endcase
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.mark = 1'b0;
        if (cs_n) begin
            seq_d.st    = SQ_IDLE;
            seq_d.drive = 1'b0;
            seq_d.dout  = '0;
            seq_d.cnt   = '0;
        end else begin
            case (seq_q.st)
                SQ_IDLE: begin
                    if (last_byte) begin
                        seq_d.addr = cmd_addr;
                        if (opcode == OP_READ_NOW ||
                            (opcode == OP_READ_LATE && WAIT_CYCLES == 0)) begin
                            seq_d.st    = SQ_DATA;
                            seq_d.drive = 1'b1;
                            seq_d.dout  = rd_data;
                        end else if (opcode == OP_READ_LATE) begin
                            seq_d.st  = SQ_WAIT;
                            seq_d.cnt = CW'(WAIT_CYCLES);
                        end else begin
                            seq_d.st    = SQ_FILL;
                            seq_d.drive = 1'b1;
                            seq_d.dout  = FILL_VALUE;
                        end
                    end
                end
                SQ_WAIT: begin
                    if (seq_q.cnt <= CW'(1)) begin
                        seq_d.st    = SQ_DATA;
                        seq_d.drive = 1'b1;
                        seq_d.dout  = rd_data;
                    end else begin
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
                SQ_DATA: begin
                    seq_d.addr = rd_addr;
                    seq_d.dout = rd_data;
                    seq_d.mark = (rd_addr[MW-1:0] == '0);
                end
                SQ_FILL: begin
                    seq_d.dout = FILL_VALUE;
                end
                default: begin
                    seq_d.st = SQ_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign drive = seq_q.drive;
    assign dout  = seq_q.dout;
    assign mark  = seq_q.mark;

endmodule

// File: rtl/cart_responder.sv
`timescale 1ns/1ps
module cart_responder #(
    parameter int MEM_BYTES   = 1024,
    parameter int BLOCK_BYTES = 512,
    parameter int WAIT_CYCLES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic [7:0] dq_in,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    output logic       blk_mark
);
    localparam int AW = $clog2(MEM_BYTES);

    logic          cmd_last;
    logic [7:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_data;
    logic          seq_drive;
    logic [7:0]    seq_dout;
    logic          seq_mark;

    cart_cmd_capture #(.AW(AW)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .din        (dq_in),
        .last_byte  (cmd_last),
        .opcode     (cmd_op),
        .start_addr (cmd_addr)
    );

    cart_rom #(.MEM_BYTES(MEM_BYTES)) u_rom (
        .rd_addr (rom_addr),
        .rd_data (rom_data)
    );

    cart_seq #(
        .AW          (AW),
        .BLOCK_BYTES (BLOCK_BYTES),
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .last_byte (cmd_last),
        .opcode    (cmd_op),
        .cmd_addr  (cmd_addr),
        .rd_addr   (rom_addr),
        .rd_data   (rom_data),
        .drive     (seq_drive),
        .dout      (seq_dout),
        .mark      (seq_mark)
    );

    // Deselect releases the pins without waiting for a clock edge.
    assign dq_oe    = seq_drive & ~cs_n;
    assign dq_out   = dq_oe ? seq_dout : 8'h00;
    assign blk_mark = seq_mark & ~cs_n;

endmodule

// File: rtl/cart_responder_chk.sv
`timescale 1ns/1ps
module cart_responder_chk #(
    parameter int WAIT_CYCLES = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       last_byte,
    input logic [7:0] opcode,
    input logic       drive_q,
    input logic       dq_oe,
    input logic [7:0] dq_out,
    input logic       blk_mark
);
    import cart_pkg::*;

    logic known_op;
    assign known_op = (opcode == OP_READ_NOW) || (opcode == OP_READ_LATE);

    // R10: an edge seen with select high leaves the driver off
    p_deselect_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !drive_q);

    // R2: nothing is driven while the last command byte is taken
    p_quiet_command_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_byte |-> !drive_q);

    // R4: immediate read drives on the edge after the command
    p_fast_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && opcode == OP_READ_NOW) |=> (drive_q || cs_n));

    // R5: delayed read keeps the bus released after the command
    p_late_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byte && opcode == OP_READ_LATE && WAIT_CYCLES > 0) |=> !drive_q);

    // R8: a block mark only accompanies a driven byte
    p_mark_driven_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_mark |-> dq_oe);

    // R9: unknown opcode yields 0xFF whenever driving
    p_fill_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && !known_op) |-> (dq_out == FILL_VALUE));

endmodule

bind cart_responder cart_responder_chk #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .last_byte (cmd_last),
    .opcode    (cmd_op),
    .drive_q   (seq_drive),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out),
    .blk_mark  (blk_mark)
);

// File: tb/cart_responder_test.sv
`timescale 1ns/1ps
module cart_responder_test;

    localparam int MEM   = 1024;
    localparam int BLK   = 512;
    localparam int WAITC = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [7:0] dq_in = 8'h00;
    logic [7:0] dq_out;
    logic       dq_oe;
    logic       blk_mark;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cart_responder #(.MEM_BYTES(MEM), .BLOCK_BYTES(BLK), .WAIT_CYCLES(WAITC)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .dq_in    (dq_in),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe),
        .blk_mark (blk_mark)
    );

    function automatic logic [7:0] ref_cell(input int unsigned a);
        int unsigned s;
        s = 37 * a + 11 * (a / 256) + 29;
        return 8'(s % 256);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R2: eight command bytes, bus checked released before each byte is driven
    task automatic send_cmd(input logic [7:0] op, input logic [31:0] addr, input logic [23:0] tail);
        logic [7:0] b [8];
        b[0] = op; b[1] = addr[31:24]; b[2] = addr[23:16]; b[3] = addr[15:8];
        b[4] = addr[7:0]; b[5] = tail[23:16]; b[6] = tail[15:8]; b[7] = tail[7:0];
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R2 oe during command", {31'd0, dq_oe}, 32'd0);
            cs_n  = 1'b0;
            dq_in = b[k];
        end
    endtask

    // R6 R7 R8 R11: stream of n bytes from start
    task automatic expect_stream(input int unsigned start, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            int unsigned a;
            a = (start + i) % MEM;
            @(negedge clk);
            chk({req, " R6 oe"}, {31'd0, dq_oe}, 32'd1);
            chk({req, " R7 data"}, {24'd0, dq_out}, {24'd0, ref_cell(a)});
            chk({req, " R8 mark"}, {31'd0, blk_mark}, {31'd0, (i > 0) && (a % BLK == 0)});
            dq_in = 8'(i * 29 + 3); // R11 noise on the input pins
        end
    endtask

    // R10: select rise releases immediately
    task automatic end_xfer();
        cs_n = 1'b1;
        #1;
        chk("R10 release on deselect", {31'd0, dq_oe}, 32'd0);
        @(negedge clk);
        chk("R10 idle after deselect", {31'd0, dq_oe}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", {31'd0, dq_oe}, 32'd0);
        chk("R1 data after reset", {24'd0, dq_out}, 32'd0);
        chk("R1 mark after reset", {31'd0, blk_mark}, 32'd0);
    endtask

    task automatic t_fast();
        send_cmd(8'hB7, 32'h0000_0010, 24'hAA55C3);
        expect_stream(32'h10, 5, "R4 immediate");
        end_xfer();
    endtask

    task automatic t_block_cross();
        send_cmd(8'hB7, 32'h0000_01FD, 24'h000000);
        expect_stream(32'h1FD, 6, "R8 crossing");
        end_xfer();
    endtask

    task automatic t_block_start();
        send_cmd(8'hB7, 32'h0000_0200, 24'h010203);
        expect_stream(32'h200, 3, "R8 first byte on boundary");
        end_xfer();
    endtask

    task automatic t_wrap();
        send_cmd(8'hB7, 32'h1234_07FE, 24'h777777);
        expect_stream(32'h3FE, 4, "R3 R6 modulo and wrap");
        end_xfer();
    endtask

    task automatic t_tail_ignored();
        send_cmd(8'hB7, 32'h0000_0080, 24'hFFFFFF);
        expect_stream(32'h80, 3, "R3 tail bytes ignored");
        end_xfer();
    endtask

    task automatic t_late();
        send_cmd(8'h3C, 32'h0000_0040, 24'h112233);
        for (int w = 0; w < WAITC; w++) begin
            @(negedge clk);
            chk("R5 released during latency", {31'd0, dq_oe}, 32'd0);
        end
        expect_stream(32'h40, 4, "R5 delayed");
        end_xfer();
    endtask

    task automatic t_unknown();
        send_cmd(8'h5A, 32'h0000_0100, 24'h000000);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9 fill oe", {31'd0, dq_oe}, 32'd1);
            chk("R9 fill value", {24'd0, dq_out}, 32'hFF);
        end
        end_xfer();
    endtask

    task automatic t_abort();
        send_cmd(8'hB7, 32'h0000_0300, 24'h000000);
        expect_stream(32'h300, 2, "R10 before abort");
        end_xfer();
        send_cmd(8'hB7, 32'h0000_0020, 24'h000000);
        expect_stream(32'h20, 3, "R10 fresh transfer");
        end_xfer();
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fast();
        t_block_cross();
        t_block_start();
        t_wrap();
        t_tail_ignored();
        t_late();
        t_unknown();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule